// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes the write cycles that a host places on the bus of a parallel NOR-style flash. Each write carries an address and a data word, and the low byte of the data is the command byte. Single-cycle commands choose what a read returns: array contents, identifier codes, a query table or the status byte. They also clear the sticky error bits. Multi-cycle commands are collected before anything starts. These cover word program, block erase, buffered program, lock-bit set and clear-all, and protection-register program. Once such a command is complete and legal, the block sends one start pulse to an operation engine, together with the operation code, address, data and entry count.

The engine is modelled as a busy/done/fail handshake. While it is busy, only a status-mode command and a suspend command take effect. A suspended operation is resumed by a single confirm cycle. A buffered program stores its entries in an internal buffer, which the engine then reads back by index. The block keeps one lock bit per block. A program or erase aimed at a locked block is refused, and the refusal shows up in the status byte.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (`rd_mode_o`=0, `rdata_o`=`array_data_i`), no start pulse is issued, and the status byte reads 80h.
- R2: Command FFh selects array mode (0), 90h selects identifier mode (1), 98h selects query mode (2) and 70h selects status mode (3). In identifier mode, address offset 0 returns MFR_CODE, offset 1 returns DEV_CODE and offset 2 returns the lock bit of the addressed block. In query mode, offsets 10h/11h/12h return 51h/52h/59h. An unrecognised byte written in idle leaves the mode unchanged.
- R3: 40h or 10h followed by a second cycle produces one start pulse one clock after that cycle, with `op_o`=1 and the second cycle's address and data. The mode then becomes status.
- R4: 20h followed by D0h produces a start pulse with `op_o`=2 and the confirm cycle's address. Any other confirm byte sets the sequence-error bit (status bit 3) and issues no start.
- R5: E8h, then a count n, then n+1 data cycles in the same block, then D0h, produces a start pulse with `op_o`=3, the block base address and `op_count_o`=n. Entry i is readable on `buf_addr_o`/`buf_data_o` when `buf_idx_i`=i.
- R6: The buffered program aborts and sets status bit 3, with no start, in three cases: a non-D0h byte arrives after the n+1 data cycles, a data cycle falls outside the starting block, or n exceeds 1Fh in byte mode or 0Fh in word mode.
- R7: 60h followed by 01h sets the lock bit of the addressed block. 60h followed by D0h clears all lock bits.
- R8: A program, erase or buffered program aimed at a locked block issues no start. It sets status bit 1, together with bit 4 (program) or bit 5 (erase).
- R9: In status mode while the engine is busy, only bit 7 is driven (`rdata_oe_o`=0080h) and it reads 0.
- R10: While the engine is busy, every command other than 70h and B0h is ignored.
- R11: B0h during a busy erase or program produces a `suspend_o` pulse and sets status bit 6 (erase) or bit 2 (program). While suspended, D0h produces a `resume_o` pulse and clears those bits.
- R12: `eng_done_i` with `eng_fail_i` sets status bit 5 after an erase, or bit 4 after a program. 50h clears bits 5, 4, 3 and 1.
- R13: C0h followed by a second cycle produces a start pulse with `op_o`=4 and that cycle's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write cycle strobe |
| addr_i | input | ADDR_W | Bus address for writes and reads |
| wdata_i | input | DATA_W | Write data; the low byte is the command |
| byte_mode_i | input | 1 | 1: byte-wide buffer count limit, 0: word-wide |
| eng_busy_i | input | 1 | Engine busy |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_fail_i | input | 1 | Engine failure, valid with done |
| array_data_i | input | DATA_W | Array data for array-mode reads |
| start_o | output | 1 | One-cycle operation start |
| op_o | output | 3 | Operation: 1 program, 2 erase, 3 buffered, 4 protection |
| op_addr_o | output | ADDR_W | Operation address |
| op_data_o | output | DATA_W | Operation data |
| op_count_o | output | 5 | Buffered entry count minus one |
| suspend_o | output | 1 | Suspend pulse to engine |
| resume_o | output | 1 | Resume pulse to engine |
| buf_idx_i | input | 5 | Buffer read index from engine |
| buf_addr_o | output | ADDR_W | Buffered entry address |
| buf_data_o | output | DATA_W | Buffered entry data |
| rdata_o | output | DATA_W | Read data |
| rdata_oe_o | output | DATA_W | Per-bit read output enable |
| rd_mode_o | output | 2 | Current read mode |

## Verification
Program setup is tried with both of its setup bytes, and erase with both a correct and a wrong confirm, so that an accepted alias can be told apart from a rejected sequence. Buffered writes are tried with a short count, the largest byte-mode count and the largest word-mode count. They are also tried with a count one above the word limit, a wrong confirm byte and an out-of-block entry. Together these separate a correct length count from an off-by-one count and a missing block check. Erase and program commands are sent to a locked block and then to the same block after the clear-all, which shows that the lock state really gates the start. Commands written while the engine is busy are followed, once it is idle, by a bare confirm byte that would start an erase if the earlier setup had been taken. Suspend is tried on both an erase and a program, so the correct suspend bit can be distinguished.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_QUERY, RD_STATUS} rd_mode_e;
  typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE, OP_BUF, OP_PROT} op_e;
  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_BCNT, S_BDATA, S_BCONF, S_LOCK, S_PROT} seq_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLRSR   = 8'h50;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_BUFWR   = 8'hE8;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_LOCKSET = 8'h01;
  localparam logic [7:0] C_PROT    = 8'hC0;
endpackage

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int NUM_BLK = 16,
  localparam int BLK_W = $clog2(NUM_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic             clr_all_i,
  input  logic [BLK_W-1:0] chk_blk_i,
  output logic             chk_o,
  input  logic [BLK_W-1:0] id_blk_i,
  output logic             id_o
);
  logic [NUM_BLK-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bits_q <= '0;
    else if (clr_all_i) bits_q <= '0;
    else if (set_i)     bits_q[set_blk_i] <= 1'b1;
  end

  assign chk_o = bits_q[chk_blk_i];
  assign id_o  = bits_q[id_blk_i];
endmodule

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      addr_mem[wr_idx_i] <= wr_addr_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_addr_o = addr_mem[rd_idx_i];
  assign rd_data_o = data_mem[rd_idx_i];
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0089,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0018
) (
  input  rd_mode_e          mode_i,
  input  logic [7:0]        offs_i,
  input  logic [7:0]        status_i,
  input  logic              busy_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] oe_o
);
  always_comb begin
    rdata_o = '0;
    oe_o    = '1;
    unique case (mode_i)
      RD_ARRAY: rdata_o = array_i;
      RD_IDENT: begin
        unique case (offs_i[1:0])
          2'd0:    rdata_o = MFR_CODE;
          2'd1:    rdata_o = DEV_CODE;
          2'd2:    rdata_o = DATA_W'(lock_i);
          default: rdata_o = '0;
        endcase
      end
      RD_QUERY: begin
        unique case (offs_i)
          8'h10:   rdata_o = DATA_W'(8'h51);
          8'h11:   rdata_o = DATA_W'(8'h52);
          8'h12:   rdata_o = DATA_W'(8'h59);
          8'h13:   rdata_o = DATA_W'(DEPTH);
          default: rdata_o = '0;
        endcase
      end
      default: begin
        if (busy_i) begin
          // only the ready bit is valid during an operation
          oe_o    = DATA_W'(8'h80);
          rdata_o = DATA_W'({status_i[7], 7'b0});
        end else begin
          rdata_o = DATA_W'(status_i);
        end
      end
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 8,
  parameter int BUF_DEPTH = 32,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0089,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0018,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              byte_mode_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic              start_o,
  output logic [2:0]        op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [IDX_W-1:0]  op_count_o,
  output logic              suspend_o,
  output logic              resume_o,
  input  logic [IDX_W-1:0]  buf_idx_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] rdata_oe_o,
  output logic [1:0]        rd_mode_o
);
  localparam int BLK_W   = ADDR_W - BLK_LSB;
  localparam int NUM_BLK = 1 << BLK_W;
  localparam logic [DATA_W-1:0] BYTE_MAX = DATA_W'(BUF_DEPTH - 1);
  localparam logic [DATA_W-1:0] WORD_MAX = DATA_W'(BUF_DEPTH / 2 - 1);

  seq_e              state_q;
  rd_mode_e          mode_q;
  op_e               op_q, last_op_q;
  logic              start_q, susp_q, resume_q;
  logic              er_fail_q, pg_fail_q, seq_err_q, lk_fail_q, er_susp_q, pg_susp_q;
  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  cnt_q, idx_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;

  logic [7:0]       cmd;
  logic [BLK_W-1:0] cmd_blk, chk_blk;
  logic             suspended, accept, lock_hit, id_lock;
  logic             lock_set, lock_clr, buf_we, cnt_ok;
  logic [7:0]       status;

  assign cmd       = wdata_i[7:0];
  assign cmd_blk   = addr_i[ADDR_W-1:BLK_LSB];
  assign suspended = er_susp_q | pg_susp_q;
  assign accept    = we_i & ~eng_busy_i & ~suspended;
  assign chk_blk   = (state_q == S_BCONF) ? blk_q : cmd_blk;
  assign lock_set  = accept && state_q == S_LOCK && cmd == C_LOCKSET;
  assign lock_clr  = accept && state_q == S_LOCK && cmd == C_CONFIRM;
  assign buf_we    = accept && state_q == S_BDATA && cmd_blk == blk_q;
  assign cnt_ok    = byte_mode_i ? (wdata_i <= BYTE_MAX) : (wdata_i <= WORD_MAX);
  assign status    = {~eng_busy_i, er_susp_q, er_fail_q, pg_fail_q,
                      seq_err_q, pg_susp_q, lk_fail_q, 1'b0};

  flash_lock_bits #(.NUM_BLK(NUM_BLK)) u_lock (
    .clk_i, .rst_ni,
    .set_i(lock_set), .set_blk_i(cmd_blk), .clr_all_i(lock_clr),
    .chk_blk_i(chk_blk), .chk_o(lock_hit),
    .id_blk_i(cmd_blk), .id_o(id_lock)
  );

  flash_wbuf #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk_i,
    .we_i(buf_we), .wr_idx_i(idx_q), .wr_addr_i(addr_i), .wr_data_i(wdata_i),
    .rd_idx_i(buf_idx_i), .rd_addr_o(buf_addr_o), .rd_data_o(buf_data_o)
  );

  flash_read_mux #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH),
                   .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
    .mode_i(mode_q), .offs_i(addr_i[7:0]), .status_i(status),
    .busy_i(eng_busy_i), .lock_i(id_lock), .array_i(array_data_i),
    .rdata_o, .oe_o(rdata_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      mode_q    <= RD_ARRAY;
      op_q      <= OP_NONE;
      last_op_q <= OP_NONE;
      start_q   <= 1'b0;
      susp_q    <= 1'b0;
      resume_q  <= 1'b0;
      er_fail_q <= 1'b0;
      pg_fail_q <= 1'b0;
      seq_err_q <= 1'b0;
      lk_fail_q <= 1'b0;
      er_susp_q <= 1'b0;
      pg_susp_q <= 1'b0;
      blk_q     <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      start_q  <= 1'b0;
      susp_q   <= 1'b0;
      resume_q <= 1'b0;
      if (eng_done_i && eng_fail_i) begin
        if (last_op_q == OP_ERASE) er_fail_q <= 1'b1;
        else                       pg_fail_q <= 1'b1;
      end
      if (we_i && eng_busy_i) begin
        if (cmd == C_STATUS) mode_q <= RD_STATUS;
        else if (cmd == C_SUSPEND && !suspended &&
                 last_op_q inside {OP_PROG, OP_ERASE, OP_BUF}) begin
          susp_q <= 1'b1;
          mode_q <= RD_STATUS;
          if (last_op_q == OP_ERASE) er_susp_q <= 1'b1;
          else                       pg_susp_q <= 1'b1;
        end
      end else if (we_i && suspended) begin
        unique case (cmd)
          C_ARRAY:  mode_q <= RD_ARRAY;
          C_IDENT:  mode_q <= RD_IDENT;
          C_QUERY:  mode_q <= RD_QUERY;
          C_STATUS: mode_q <= RD_STATUS;
          C_CLRSR: begin
            er_fail_q <= 1'b0; pg_fail_q <= 1'b0;
            seq_err_q <= 1'b0; lk_fail_q <= 1'b0;
          end
          C_CONFIRM: begin
            resume_q  <= 1'b1;
            er_susp_q <= 1'b0;
            pg_susp_q <= 1'b0;
            mode_q    <= RD_STATUS;
          end
          default: ;
        endcase
      end else if (accept) begin
        unique case (state_q)
          S_IDLE: begin
            unique case (cmd)
              C_ARRAY:  mode_q <= RD_ARRAY;
              C_IDENT:  mode_q <= RD_IDENT;
              C_QUERY:  mode_q <= RD_QUERY;
              C_STATUS: mode_q <= RD_STATUS;
              C_CLRSR: begin
                er_fail_q <= 1'b0; pg_fail_q <= 1'b0;
                seq_err_q <= 1'b0; lk_fail_q <= 1'b0;
              end
              C_PROG_A, C_PROG_B: state_q <= S_PROG;
              C_ERASE:            state_q <= S_ERASE;
              C_LOCK:             state_q <= S_LOCK;
              C_PROT:             state_q <= S_PROT;
              C_BUFWR: begin
                blk_q   <= cmd_blk;
                state_q <= S_BCNT;
                mode_q  <= RD_STATUS;
              end
              default: ;
            endcase
          end
          S_PROG: begin
            state_q <= S_IDLE;
            mode_q  <= RD_STATUS;
            if (lock_hit) begin
              lk_fail_q <= 1'b1; pg_fail_q <= 1'b1;
            end else begin
              start_q <= 1'b1; op_q <= OP_PROG; last_op_q <= OP_PROG;
              op_addr_q <= addr_i; op_data_q <= wdata_i;
            end
          end
          S_ERASE: begin
            state_q <= S_IDLE;
            mode_q  <= RD_STATUS;
            if (cmd != C_CONFIRM) seq_err_q <= 1'b1;
            else if (lock_hit) begin
              lk_fail_q <= 1'b1; er_fail_q <= 1'b1;
            end else begin
              start_q <= 1'b1; op_q <= OP_ERASE; last_op_q <= OP_ERASE;
              op_addr_q <= addr_i; op_data_q <= '0;
            end
          end
          S_BCNT: begin
            if (cnt_ok) begin
              cnt_q   <= wdata_i[IDX_W-1:0];
              idx_q   <= '0;
              state_q <= S_BDATA;
            end else begin
              seq_err_q <= 1'b1;
              state_q   <= S_IDLE;
            end
          end
          S_BDATA: begin
            if (cmd_blk != blk_q) begin
              seq_err_q <= 1'b1;
              state_q   <= S_IDLE;
            end else if (idx_q == cnt_q) state_q <= S_BCONF;
            else idx_q <= idx_q + 1'b1;
          end
          S_BCONF: begin
            state_q <= S_IDLE;
            if (cmd != C_CONFIRM) seq_err_q <= 1'b1;
            else if (lock_hit) begin
              lk_fail_q <= 1'b1; pg_fail_q <= 1'b1;
            end else begin
              start_q <= 1'b1; op_q <= OP_BUF; last_op_q <= OP_BUF;
              op_addr_q <= {blk_q, {BLK_LSB{1'b0}}}; op_data_q <= '0;
            end
          end
          S_LOCK: begin
            state_q <= S_IDLE;
            mode_q  <= RD_STATUS;
            if (cmd != C_LOCKSET && cmd != C_CONFIRM) seq_err_q <= 1'b1;
          end
          default: begin
            state_q <= S_IDLE;
            mode_q  <= RD_STATUS;
            start_q <= 1'b1; op_q <= OP_PROT; last_op_q <= OP_PROT;
            op_addr_q <= addr_i; op_data_q <= wdata_i;
          end
        endcase
      end
    end
  end

  assign start_o    = start_q;
  assign op_o       = op_q;
  assign op_addr_o  = op_addr_q;
  assign op_data_o  = op_data_q;
  assign op_count_o = cnt_q;
  assign suspend_o  = susp_q;
  assign resume_o   = resume_q;
  assign rd_mode_o  = mode_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              eng_busy_i,
  input logic              start_o,
  input logic [2:0]        op_o,
  input logic [1:0]        rd_mode_o,
  input logic [DATA_W-1:0] rdata_oe_o,
  input logic              suspend_o,
  input logic              resume_o
);
  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  start_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> rd_mode_o == 2'd3);
  // R13
  start_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> op_o != 3'd0);
  // R10
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(eng_busy_i));
  // R9
  busy_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_o == 2'd3 && eng_busy_i) |-> rdata_oe_o == DATA_W'(8'h80));
  // R11
  suspend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(eng_busy_i) && $past(we_i));
  // R11
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> !$past(eng_busy_i) && $past(wdata_i[7:0]) == 8'hD0);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
  .eng_busy_i(eng_busy_i), .start_o(start_o), .op_o(op_o),
  .rd_mode_o(rd_mode_o), .rdata_oe_o(rdata_oe_o),
  .suspend_o(suspend_o), .resume_o(resume_o)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic        clk = 0, rst_ni = 0;
  logic        we = 0, byte_mode = 1, busy = 0, done = 0, fail = 0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] array_data = 16'hA5C3;
  logic [4:0]  buf_idx = '0;
  logic        start, susp, resume;
  logic [2:0]  op;
  logic [11:0] op_addr, buf_addr;
  logic [15:0] op_data, buf_data, rdata, rdata_oe;
  logic [4:0]  op_count;
  logic [1:0]  rd_mode;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  flash_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .byte_mode_i(byte_mode), .eng_busy_i(busy), .eng_done_i(done),
    .eng_fail_i(fail), .array_data_i(array_data), .start_o(start), .op_o(op),
    .op_addr_o(op_addr), .op_data_o(op_data), .op_count_o(op_count),
    .suspend_o(susp), .resume_o(resume), .buf_idx_i(buf_idx),
    .buf_addr_o(buf_addr), .buf_data_o(buf_data), .rdata_o(rdata),
    .rdata_oe_o(rdata_oe), .rd_mode_o(rd_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write cycle; returns 1 ns after the capturing edge
  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    logic [15:0] d;
    wr(12'h0, 16'h70); rd(12'h0, d);
    check(req, d, {8'h0, exp});
  endtask

  task automatic engine(input logic f);
    @(negedge clk); busy = 1;
    repeat (3) @(negedge clk);
    busy = 0; done = 1; fail = f;
    @(negedge clk); done = 0; fail = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(12'h0, d);
    check("R1 mode", rd_mode, 0);
    check("R1 array read", d, 16'hA5C3);
    check("R1 no start", start, 0);
    status_is("R1 status", 8'h80);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    wr(0, 16'h90);
    rd(12'h000, d); check("R2 mfr", d, 16'h0089);
    rd(12'h001, d); check("R2 dev", d, 16'h0018);
    rd(12'h302, d); check("R2 lock clear", d, 0);
    wr(0, 16'h98);
    rd(12'h010, d); check("R2 query Q", d, 16'h51);
    rd(12'h012, d); check("R2 query Y", d, 16'h59);
    wr(0, 16'h33);
    check("R2 unknown keeps mode", rd_mode, 2);
    wr(0, 16'hFF);
    rd(12'h0, d); check("R2 array", d, 16'hA5C3);
  endtask

  task automatic t_prog();
    wr(0, 16'h40);
    check("R3 no start at setup", start, 0);
    wr(12'h123, 16'hBEEF);
    check("R3 start", start, 1);
    check("R3 op", op, 1);
    check("R3 addr", op_addr, 12'h123);
    check("R3 data", op_data, 16'hBEEF);
    check("R3 status mode", rd_mode, 3);
    @(posedge clk); #1;
    check("R3 single pulse", start, 0);
    wr(0, 16'h10); wr(12'h456, 16'h1234);
    check("R3 alias start", start, 1);
    check("R3 alias data", op_data, 16'h1234);
  endtask

  task automatic t_erase();
    wr(12'h200, 16'h20); wr(12'h210, 16'hD0);
    check("R4 start", start, 1);
    check("R4 op", op, 2);
    check("R4 addr", op_addr, 12'h210);
    wr(12'h200, 16'h20); wr(12'h200, 16'h33);
    check("R4 bad confirm no start", start, 0);
    status_is("R4 seq error", 8'h88);
    wr(0, 16'h50);
    status_is("R12 clear", 8'h80);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr(12'h300, 16'h60); wr(12'h300, 16'h01);
    wr(0, 16'h90);
    rd(12'h302, d); check("R7 lock set", d, 1);
    rd(12'h202, d); check("R7 other block", d, 0);
    wr(0, 16'h40); wr(12'h310, 16'h55);
    check("R8 prog no start", start, 0);
    status_is("R8 prog status", 8'h92);
    wr(0, 16'h50);
    wr(12'h300, 16'h20); wr(12'h300, 16'hD0);
    check("R8 erase no start", start, 0);
    status_is("R8 erase status", 8'hA2);
    wr(0, 16'h50);
    wr(12'h300, 16'hE8); wr(12'h300, 16'h0); wr(12'h300, 16'h11); wr(12'h300, 16'hD0);
    check("R8 buf no start", start, 0);
    status_is("R8 buf status", 8'h92);
    wr(0, 16'h50);
    wr(0, 16'h60); wr(0, 16'hD0);
    wr(0, 16'h90);
    rd(12'h302, d); check("R7 clear all", d, 0);
    wr(12'h300, 16'h20); wr(12'h300, 16'hD0);
    check("R7 erase after clear", start, 1);
  endtask

  task automatic buf_write(input logic [11:0] base, input int n, input logic [7:0] conf);
    wr(base, 16'hE8); wr(base, 16'(n));
    for (int i = 0; i <= n; i++) wr(base + 12'(i), 16'h1000 + 16'(i));
    wr(base, {8'h0, conf});
  endtask

  task automatic t_buf();
    byte_mode = 1;
    buf_write(12'h200, 3, 8'hD0);
    check("R5 start", start, 1);
    check("R5 op", op, 3);
    check("R5 base", op_addr, 12'h200);
    check("R5 count", op_count, 3);
    buf_idx = 2; #1;
    check("R5 entry data", buf_data, 16'h1002);
    check("R5 entry addr", buf_addr, 12'h202);
    buf_write(12'h100, 31, 8'hD0);
    check("R5 full byte count", start, 1);
    check("R5 full count", op_count, 31);
    buf_idx = 31; #1;
    check("R5 last entry", buf_data, 16'h101F);
    byte_mode = 0;
    buf_write(12'h100, 15, 8'hD0);
    check("R5 word max", start, 1);
  endtask

  task automatic t_abort();
    byte_mode = 1;
    buf_write(12'h200, 1, 8'h55);
    check("R6 wrong confirm", start, 0);
    status_is("R6 wrong confirm status", 8'h88);
    wr(0, 16'h50);
    wr(12'h200, 16'hE8); wr(12'h200, 16'h2); wr(12'h305, 16'h77);
    check("R6 out of block", start, 0);
    status_is("R6 out of block status", 8'h88);
    wr(0, 16'h50);
    byte_mode = 0;
    wr(12'h200, 16'hE8); wr(12'h200, 16'h10);
    status_is("R6 count limit", 8'h88);
    wr(0, 16'h50);
    byte_mode = 1;
  endtask

  task automatic t_busy();
    logic [15:0] d;
    wr(0, 16'h40); wr(12'h010, 16'h0001);
    check("R10 start", start, 1);
    @(negedge clk); busy = 1;
    rd(0, d);
    check("R9 ready low", d, 0);
    check("R9 oe bit7 only", rdata_oe, 16'h0080);
    wr(0, 16'h20); wr(0, 16'hFF);
    check("R10 ignored mode", rd_mode, 3);
    @(negedge clk); busy = 0; done = 1;
    @(negedge clk); done = 0;
    wr(0, 16'hD0);
    check("R10 setup ignored", start, 0);
    status_is("R10 status clean", 8'h80);
  endtask

  task automatic t_suspend();
    wr(12'h100, 16'h20); wr(12'h100, 16'hD0);
    @(negedge clk); busy = 1;
    wr(0, 16'hB0);
    check("R11 suspend pulse", susp, 1);
    @(negedge clk); busy = 0;
    status_is("R11 erase suspended", 8'hC0);
    wr(0, 16'hFF);
    wr(0, 16'hD0);
    check("R11 resume pulse", resume, 1);
    check("R11 resume no start", start, 0);
    status_is("R11 resumed", 8'h80);
    wr(0, 16'h40); wr(12'h020, 16'h5);
    @(negedge clk); busy = 1;
    wr(0, 16'hB0);
    @(negedge clk); busy = 0;
    status_is("R11 program suspended", 8'h84);
    wr(0, 16'hD0);
    check("R11 resume program", resume, 1);
  endtask

  task automatic t_fail();
    wr(12'h100, 16'h20); wr(12'h100, 16'hD0);
    engine(1);
    status_is("R12 erase fail", 8'hA0);
    wr(0, 16'h50);
    wr(0, 16'h40); wr(12'h040, 16'h9);
    engine(1);
    status_is("R12 program fail", 8'h90);
    wr(0, 16'h50);
    status_is("R12 cleared", 8'h80);
  endtask

  task automatic t_prot();
    wr(0, 16'hC0); wr(12'h081, 16'hCAFE);
    check("R13 start", start, 1);
    check("R13 op", op, 4);
    check("R13 addr", op_addr, 12'h081);
    check("R13 data", op_data, 16'hCAFE);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_modes();
    t_prog();
    t_erase();
    t_lock();
    t_buf();
    t_abort();
    t_busy();
    t_suspend();
    t_fail();
    t_prot();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule